// File: doc/BRIEF.md
# Word Adder-Subtractor with Overflow and Set-Less-Than

This unit does integer arithmetic on two 32-bit words. It can add them. It can subtract the second from the first by adding the first to the inverted second operand with the carry input held high. It can also compare the two words as signed or unsigned numbers. All four operations share one carry-chain adder. The comparisons read the sign of the difference, the overflow condition and the carry out of that adder.

The unit has no storage and no clock. A new operand pair and operation code give a settled result, overflow flag and carry within the same cycle. A surrounding datapath registers these outputs wherever its pipeline needs them.

Top module: `addsub_cmp_unit`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals (op_a + op_b) mod 2^32. The sign bit gets no special treatment, so 0xFFFFFFFF + 0xFFFFFFFF gives 0xFFFFFFFE.
- R2: With op_sel = 2'b01 (subtract), result equals (op_a + ~op_b + 1) mod 2^32, which is op_a minus op_b with the borrow wrapped.
- R3: For add, ovf is 1 exactly when both operands have the same sign bit (bit 31) and the result's sign bit differs from it.
- R4: For subtract, ovf is 1 exactly when the operands' sign bits differ and the result's sign bit differs from that of op_a.
- R5: For add, carry_out is the carry out of bit 31, that is 1 exactly when the unsigned sum reaches 2^32.
- R6: For subtract, carry_out is 1 exactly when op_a is greater than or equal to op_b as unsigned numbers (no borrow).
- R7: With op_sel = 2'b10 (signed less-than), result is 32'd1 when op_a < op_b as two's complement numbers, and 32'd0 otherwise. A set bit 31 marks the smaller value.
- R8: With op_sel = 2'b11 (unsigned less-than), result is 32'd1 when op_a < op_b as unsigned numbers, and 32'd0 otherwise. A set bit 31 marks the larger value.
- R9: For both less-than operations, ovf is 0. carry_out is 1 exactly when op_a >= op_b as unsigned numbers.
- R10: The outputs depend only on the present inputs. They are valid in the same cycle that the inputs change, and no earlier input affects them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (minuend for subtract and compare) |
| op_b | input | 32 | Second operand (subtrahend for subtract and compare) |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 signed less-than, 11 unsigned less-than |
| result | output | 32 | Sum, difference, or 0/1 comparison outcome |
| ovf | output | 1 | Signed overflow of add or subtract; 0 for comparisons |
| carry_out | output | 1 | Carry out of bit 31 of the shared adder |

## Verification
All three outputs are combinational, so each one is due zero cycles after its stimulus. The bench drives a new operand pair and operation just after a rising edge. It compares result, ovf and carry_out against a behavioural model on the following falling edge, within the same cycle. Because the next stimulus is applied only after the next rising edge, every sample sees inputs that have settled and were applied one at a time. The R10 check changes the inputs back to back and confirms that no earlier value carries over into the outputs.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_SLT  = 2'b10,
    OP_SLTU = 2'b11
  } alu_op_e;

  function automatic logic op_is_compare(input alu_op_e op);
    return (op == OP_SLT) || (op == OP_SLTU);
  endfunction

endpackage

// File: rtl/operand_prep.sv
module operand_prep
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw_b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] eff_b,
  output logic              carry_in
);

  logic negate;

  // Everything except a plain add works on A + (~B) + 1.
  always_comb begin
    negate   = (op != OP_ADD);
    eff_b    = negate ? ~raw_b : raw_b;
    carry_in = negate;
  end

endmodule

// File: rtl/carry_chain_adder.sv
module carry_chain_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] in_x,
  input  logic [DATA_W-1:0] in_y,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);

  logic [DATA_W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic prop;
    assign prop         = in_x[i] ^ in_y[i];
    assign sum[i]       = prop ^ chain[i];
    assign chain[i+1]   = (in_x[i] & in_y[i]) | (prop & chain[i]);
  end

  assign cout = chain[DATA_W];

endmodule

// File: rtl/result_select.sv
module result_select
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] eff_b,
  input  logic [DATA_W-1:0] sum,
  input  logic              adder_cout,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);

  localparam int MSB = DATA_W - 1;

  logic raw_ovf;
  logic less_signed;
  logic less_unsigned;
  logic less_pick;

  always_comb begin
    // Same-sign inputs to the adder whose sum flips sign cannot be represented.
    raw_ovf       = (lhs[MSB] == eff_b[MSB]) && (sum[MSB] != lhs[MSB]);
    less_signed   = sum[MSB] ^ raw_ovf;
    less_unsigned = ~adder_cout;
    less_pick     = (op == OP_SLT) ? less_signed : less_unsigned;

    if (op_is_compare(op)) begin
      result = {{(DATA_W-1){1'b0}}, less_pick};
      ovf    = 1'b0;
    end else begin
      result = sum;
      ovf    = raw_ovf;
    end
  end

endmodule

// File: rtl/addsub_cmp_unit.sv
module addsub_cmp_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        op_sel,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              carry_out
);

  localparam int MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [DATA_W-1:0] sum;

  assign op = alu_op_e'(op_sel);

  operand_prep #(.DATA_W(DATA_W)) u_prep (
    .raw_b    (op_b),
    .op       (op),
    .eff_b    (b_eff),
    .carry_in (cin)
  );

  carry_chain_adder #(.DATA_W(DATA_W)) u_adder (
    .in_x (op_a),
    .in_y (b_eff),
    .cin  (cin),
    .sum  (sum),
    .cout (carry_out)
  );

  result_select #(.DATA_W(DATA_W)) u_sel (
    .op         (op),
    .lhs        (op_a),
    .eff_b      (b_eff),
    .sum        (sum),
    .adder_cout (carry_out),
    .result     (result),
    .ovf        (ovf)
  );

  // Checks on the assembled outputs, phrased on the original operands.
  always_comb begin
    if (op_sel == 2'b00 && ovf) begin
      assert_add_ovf_same_sign_R3: assert (op_a[MSB] == op_b[MSB]);
    end
    if (op_sel == 2'b01 && ovf) begin
      assert_sub_ovf_mixed_sign_R4: assert (op_a[MSB] != op_b[MSB]);
    end
    if (op_sel == 2'b00 && !op_a[MSB] && !op_b[MSB]) begin
      assert_add_small_no_carry_R5: assert (!carry_out);
    end
    if (op_sel == 2'b01 && op_b == '0) begin
      assert_sub_zero_identity_R2: assert (result == op_a && carry_out);
    end
    if (op_sel[1]) begin
      assert_cmp_no_ovf_R9: assert (!ovf);
      assert_cmp_one_bit_R7: assert (result[MSB:1] == '0);
    end
    if (op_sel[1] && op_a == op_b) begin
      assert_cmp_equal_false_R8: assert (result == '0 && carry_out);
    end
  end

endmodule

// File: tb/addsub_cmp_unit_test.sv
module addsub_cmp_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] result;
  logic        ovf;
  logic        carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 4 ns period

  addsub_cmp_unit uut (
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .result    (result),
    .ovf       (ovf),
    .carry_out (carry_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (op=%b a=%h b=%h)", req, act, exp, op_sel, op_a, op_b);
    end
  endtask

  task automatic model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic o, output logic c);
    longint sa;
    longint sb;
    longint sr;
    logic [32:0] wide;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b00: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[31:0];
        c = wide[32];
        sr = sa + sb;
        o = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      2'b01: begin
        r = a - b;
        c = (a >= b);
        sr = sa - sb;
        o = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      2'b10: begin
        r = (sa < sb) ? 32'd1 : 32'd0;
        c = (a >= b);
        o = 1'b0;
      end
      default: begin
        r = (a < b) ? 32'd1 : 32'd0;
        c = (a >= b);
        o = 1'b0;
      end
    endcase
  endtask

  function automatic string res_tag(input logic [1:0] op);
    case (op)
      2'b00:   return "R1 add result";
      2'b01:   return "R2 sub result";
      2'b10:   return "R7 signed less-than";
      default: return "R8 unsigned less-than";
    endcase
  endfunction

  function automatic string ovf_tag(input logic [1:0] op);
    case (op)
      2'b00:   return "R3 add overflow";
      2'b01:   return "R4 sub overflow";
      default: return "R9 compare overflow";
    endcase
  endfunction

  function automatic string cy_tag(input logic [1:0] op);
    case (op)
      2'b00:   return "R5 add carry";
      2'b01:   return "R6 sub carry";
      default: return "R9 compare carry";
    endcase
  endfunction

  // Drive after a rising edge, compare on the following falling edge (same cycle).
  task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic eo;
    logic ec;
    @(posedge clk);
    #1;
    op_sel = op;
    op_a   = a;
    op_b   = b;
    model(op, a, b, er, eo, ec);
    @(negedge clk);
    check(res_tag(op), result, er);
    check(ovf_tag(op), {31'b0, ovf}, {31'b0, eo});
    check(cy_tag(op), {31'b0, carry_out}, {31'b0, ec});
  endtask

  function automatic logic [31:0] pick_operand();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Inputs held at zero through reset: add of 0 + 0.
    check("R1 reset state result", result, 32'h0);
    check("R3 reset state overflow", {31'b0, ovf}, 32'h0);
    check("R5 reset state carry", {31'b0, carry_out}, 32'h0);

    // R1: -1 + -1 wraps to -2 with the carry discarded from the word.
    apply(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R1 minus one plus minus one", result, 32'hFFFF_FFFE);
    check("R5 carry of -1 + -1", {31'b0, carry_out}, 32'h1);

    // R3 corners
    apply(2'b00, 32'h7FFF_FFFF, 32'h0000_0001);
    check("R3 max plus one overflows", {31'b0, ovf}, 32'h1);
    apply(2'b00, 32'h8000_0000, 32'h8000_0000);
    check("R3 min plus min overflows", {31'b0, ovf}, 32'h1);
    apply(2'b00, 32'h7FFF_FFFF, 32'h8000_0000);
    check("R3 mixed signs never overflow", {31'b0, ovf}, 32'h0);

    // R4 / R6 corners
    apply(2'b01, 32'h8000_0000, 32'h0000_0001);
    check("R4 min minus one overflows", {31'b0, ovf}, 32'h1);
    apply(2'b01, 32'h0000_0000, 32'h8000_0000);
    check("R4 zero minus min overflows", {31'b0, ovf}, 32'h1);
    apply(2'b01, 32'h0000_0005, 32'h0000_0005);
    check("R2 equal operands give zero", result, 32'h0);
    check("R6 equal operands no borrow", {31'b0, carry_out}, 32'h1);
    apply(2'b01, 32'h0000_0003, 32'h0000_0005);
    check("R2 three minus five", result, 32'hFFFF_FFFE);
    check("R6 borrow on smaller minuend", {31'b0, carry_out}, 32'h0);

    // R7 / R8: leading bit reads oppositely
    apply(2'b10, 32'hFFFF_FFFF, 32'h0000_0001);
    check("R7 minus one below one", result, 32'h1);
    apply(2'b11, 32'hFFFF_FFFF, 32'h0000_0001);
    check("R8 all ones above one", result, 32'h0);
    apply(2'b10, 32'h8000_0000, 32'h7FFF_FFFF);
    check("R7 min below max (overflowing difference)", result, 32'h1);
    check("R9 no overflow on compare", {31'b0, ovf}, 32'h0);
    apply(2'b11, 32'h8000_0000, 32'h7FFF_FFFF);
    check("R8 sign bit set is larger", result, 32'h0);
    apply(2'b10, 32'h1234_5678, 32'h1234_5678);
    check("R7 equal is not less", result, 32'h0);

    // R10: back-to-back different operations, no carry-over of history
    apply(2'b11, 32'h0000_0001, 32'hFFFF_FFFF);
    check("R10 sltu then", result, 32'h1);
    apply(2'b00, 32'h0000_0002, 32'h0000_0003);
    check("R10 add immediately after compare", result, 32'h5);
    check("R10 no stale overflow", {31'b0, ovf}, 32'h0);
    apply(2'b01, 32'h0000_0005, 32'h0000_0003);
    check("R10 encoding 01 subtracts", result, 32'h2);

    for (int i = 0; i < 3000; i++) begin
      apply(2'($urandom_range(0, 3)), pick_operand(), pick_operand());
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule